// File: doc/BRIEF.md
# Tri-Level Strap Address Latch and Matcher

This block gives an SMBus target its 7-bit device address from two three-state strap pins. Each pin arrives as an already-resolved two-bit level code: low, floating or high. The two pins together select one of nine addresses. The pins are read once, in a short sampling window that opens when power-on reset is released. The decoded address is then frozen until the next power-on reset, so later pin activity does nothing.

The bus engine hands the block each received 7-bit address with a one-cycle valid strobe. One cycle later the block returns a result strobe with two flags. One flag reports a match on the latched device address. The other reports a match on the fixed alert response address. Nothing is compared, and no result strobe is produced, until the sampling window has closed and the ready output is high.

Top module: `strap_addr_match`

## Requirements
- R1: Level codes are 2'b00 low, 2'b01 floating and 2'b10 high. With pinA low, devAddr is 0011000, 0011001 or 0011010 when pinB is low, floating or high.
- R2: With pinA floating, devAddr is 0101001, 0101010 or 0101011 when pinB is low, floating or high.
- R3: With pinA high, devAddr is 1001100, 1001101 or 1001110 when pinB is low, floating or high.
- R4: The level code 2'b11 on either pin decodes exactly as floating.
- R5: After ready rises, devAddr and the match results no longer depend on pinA or pinB, until the next reset.
- R6: ready rises on the SETTLE_CYCLES-th rising clock edge after rstN is released, and stays high. While ready is low, hitValid stays 0 even if addrValid is asserted.
- R7: When ready is high and addrValid is high at a rising edge, hitValid is 1 for exactly the following cycle. In that cycle hitDevice is 1 if rxAddr equalled devAddr.
- R8: An rxAddr of 0001100 gives hitAlert = 1 and hitDevice = 0 in the result cycle.
- R9: An rxAddr that matches neither address gives hitValid = 1 with hitDevice = 0 and hitAlert = 0. The two flags are never high together, and neither is ever high without hitValid.
- R10: While rstN is low, ready, hitValid, hitDevice, hitAlert and devAddr are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset; its release opens the sampling window |
| pinA | input | 2 | First strap pin level code |
| pinB | input | 2 | Second strap pin level code |
| addrValid | input | 1 | Strobe from the bus engine: rxAddr holds a received address |
| rxAddr | input | 7 | Received 7-bit target address |
| ready | output | 1 | Sampling finished; address latched |
| devAddr | output | 7 | Latched device address |
| hitValid | output | 1 | Result strobe, one cycle after an accepted addrValid |
| hitDevice | output | 1 | Result: device address matched |
| hitAlert | output | 1 | Result: alert response address matched |

## Verification
The embedded properties check the following on every cycle:
- ready never falls once it has risen.
- The latched address holds still while ready is high.
- No result strobe follows a cycle in which ready was low.
- The two match flags are mutually exclusive.
- Neither flag is high outside a result strobe.

Only the bench's scenarios can show the rest:
- the correctness of all sixteen pin code pairs against the nine-entry address table, including the 2'b11 aliasing;
- the exact edge on which ready rises;
- that pin changes after sampling leave both the address and the match results unchanged.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] ALERT_ADDR = 7'b0001100;

  typedef enum logic [1:0] {
    LVL_LOW   = 2'd0,
    LVL_FLOAT = 2'd1,
    LVL_HIGH  = 2'd2
  } level_e;

  typedef struct packed {
    logic latch;
    logic compare;
  } ctrlStrobe_t;

  function automatic level_e toLevel(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b10:   return LVL_HIGH;
      default: return LVL_FLOAT;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] decodeAddr(input level_e a, input level_e b);
    logic [ADDR_W-1:0] base;
    case (a)
      LVL_LOW:  base = 7'b0011000;
      LVL_HIGH: base = 7'b1001100;
      default:  base = 7'b0101001;
    endcase
    return base + ADDR_W'(b);
  endfunction
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrValid,
  output ctrlStrobe_t strobe,
  output logic        ready
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic {ST_SAMPLE, ST_RUN} state_e;
  state_e stateQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_SAMPLE;
      cntQ   <= '0;
    end else if (stateQ == ST_SAMPLE) begin
      if (cntQ == LAST) stateQ <= ST_RUN;
      else              cntQ   <= cntQ + 1'b1;
    end
  end

  always_comb begin
    strobe.latch   = (stateQ == ST_SAMPLE) && (cntQ == LAST);
    strobe.compare = (stateQ == ST_RUN) && addrValid;
    ready          = (stateQ == ST_RUN);
  end

  // R6: once ready, always ready until reset
  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);
endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              ready,
  input  logic [1:0]        pinA,
  input  logic [1:0]        pinB,
  input  logic [ADDR_W-1:0] rxAddr,
  output logic [ADDR_W-1:0] devAddr,
  output logic              hitValid,
  output logic              hitDevice,
  output logic              hitAlert
);
  logic [ADDR_W-1:0] decoded;

  always_comb decoded = decodeAddr(toLevel(pinA), toLevel(pinB));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devAddr   <= '0;
      hitValid  <= 1'b0;
      hitDevice <= 1'b0;
      hitAlert  <= 1'b0;
    end else begin
      if (strobe.latch) devAddr <= decoded;
      hitValid  <= strobe.compare;
      hitDevice <= strobe.compare && (rxAddr == devAddr);
      hitAlert  <= strobe.compare && (rxAddr == ALERT_ADDR);
    end
  end

  // R5: latched address frozen after sampling
  a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> $stable(devAddr));
  // R6: no result strobe follows a not-ready cycle
  a_r6_no_early_hit: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> !hitValid);
  // R9: flags mutually exclusive
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hitDevice, hitAlert}));
  // R9: flags only inside a result strobe
  a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (!rstN)
    (hitDevice || hitAlert) |-> hitValid);
endmodule

// File: rtl/strap_addr_match.sv
module strap_addr_match
  import strap_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pinA,
  input  logic [1:0]        pinB,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] rxAddr,
  output logic              ready,
  output logic [ADDR_W-1:0] devAddr,
  output logic              hitValid,
  output logic              hitDevice,
  output logic              hitAlert
);
  ctrlStrobe_t strobe;

  strap_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .strobe(strobe), .ready(ready)
  );

  strap_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ready(ready),
    .pinA(pinA), .pinB(pinB), .rxAddr(rxAddr), .devAddr(devAddr),
    .hitValid(hitValid), .hitDevice(hitDevice), .hitAlert(hitAlert)
  );
endmodule

// File: tb/tb_strap_addr_match.sv
`timescale 1ns/1ps
module tb_strap_addr_match;
  localparam int SETTLE = 4;

  logic clk = 0;
  logic rstN = 0;
  logic [1:0] pinA = 0, pinB = 0;
  logic addrValid = 0;
  logic [6:0] rxAddr = 0;
  logic ready, hitValid, hitDevice, hitAlert;
  logic [6:0] devAddr;

  always #2 clk = ~clk;

  strap_addr_match #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB), .addrValid(addrValid),
    .rxAddr(rxAddr), .ready(ready), .devAddr(devAddr), .hitValid(hitValid),
    .hitDevice(hitDevice), .hitAlert(hitAlert)
  );

  typedef struct {
    logic  dev;
    logic  alert;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int runCnt = 0;
  int failCnt = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    runCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] expAddr(input logic [1:0] a, input logic [1:0] b);
    int row, col;
    logic [6:0] t [9];
    t = '{7'b0011000, 7'b0011001, 7'b0011010,
          7'b0101001, 7'b0101010, 7'b0101011,
          7'b1001100, 7'b1001101, 7'b1001110};
    row = (a == 2'b00) ? 0 : (a == 2'b10) ? 2 : 1;
    col = (b == 2'b00) ? 0 : (b == 2'b10) ? 2 : 1;
    return t[row*3 + col];
  endfunction

  // driver: present one address, queue the expected result
  task automatic sendAddr(input logic [6:0] a, input logic expDev,
                          input logic expAlert, input string tag);
    exp_t e;
    e.dev = expDev; e.alert = expAlert; e.tag = tag;
    @(negedge clk);
    expQ.push_back(e);
    rxAddr = a;
    addrValid = 1;
    @(negedge clk);
    addrValid = 0;
    @(negedge clk);
  endtask

  // monitor: pop and compare on every result strobe
  always @(negedge clk) begin
    if (rstN && hitValid) begin
      if (expQ.size() == 0) begin
        check("R6 unexpected hitValid", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check({e.tag, " hitDevice"}, int'(hitDevice), int'(e.dev));
        check({e.tag, " hitAlert"}, int'(hitAlert), int'(e.alert));
      end
    end
  end

  task automatic powerUp(input logic [1:0] a, input logic [1:0] b, output int edges);
    @(negedge clk);
    rstN = 0; pinA = a; pinB = b;
    repeat (2) @(negedge clk);
    rstN = 1;
    edges = 0;
    while (!ready && edges < 20) begin
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failCnt++; runCnt++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int edges;
    repeat (2) @(negedge clk);
    // R10: reset state
    check("R10 ready", int'(ready), 0);
    check("R10 hitValid", int'(hitValid), 0);
    check("R10 hitDevice", int'(hitDevice), 0);
    check("R10 hitAlert", int'(hitAlert), 0);
    check("R10 devAddr", int'(devAddr), 0);

    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        string tag;
        logic [6:0] want;
        want = expAddr(a[1:0], b[1:0]);
        if (a == 3 || b == 3) tag = "R4";
        else if (a == 0) tag = "R1";
        else if (a == 1) tag = "R2";
        else tag = "R3";

        // R6: address presented before ready must give no strobe
        @(negedge clk);
        rstN = 0; pinA = a[1:0]; pinB = b[1:0];
        @(negedge clk);
        check("R10 devAddr in reset", int'(devAddr), 0);
        rstN = 1;
        rxAddr = want; addrValid = 1;
        @(negedge clk);
        addrValid = 0;
        check("R6 no hit before ready", int'(hitValid), 0);

        powerUp(a[1:0], b[1:0], edges);
        check("R6 ready edge", edges, SETTLE);
        check({tag, " devAddr"}, int'(devAddr), int'(want));

        sendAddr(want, 1, 0, "R7");
        sendAddr(7'b0001100, 0, 1, "R8");
        sendAddr(7'h7F, 0, 0, "R9");
        sendAddr(want ^ 7'h01, 0, 0, "R9");

        // R5: pin changes after sampling are ignored
        pinA = ~a[1:0]; pinB = a[1:0] ^ 2'b10;
        repeat (3) @(negedge clk);
        check("R5 devAddr frozen", int'(devAddr), int'(want));
        sendAddr(want, 1, 0, "R5");
        check("R6 ready stays", int'(ready), 1);
      end
    end
    repeat (3) @(negedge clk);
    check("R7 all results seen", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule